// File: doc/BRIEF.md
# Burst SPI Master with Frame Timing

This block is a synchronous serial master that sends 8-bit frames, most significant bit first. Words come from a two-entry transmit queue, and the bytes it receives go to a holding register. The serial clock runs at a rate set by a divider. Both clock polarity and clock phase can be configured. Three delays can be added, each counted in whole bit times: a setup delay after chip select falls, a spacing delay between frames, and a hold delay after the final frame.

Chip select stays low for an entire burst of frames. A frame is the last of its burst when the queue is empty at the moment that frame finishes. At that point the shift register has also drained. The hold delay and the spacing delay both run to their full length. A word written while either delay is running does not cut it short. That word is sent once the delay ends, and chip select stays low throughout. The serial clock stays at its idle level during every delay, so no extra pulse appears. The first data bit of each word is always launched on the regular edge.

Words enter through a valid/ready write port. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the queue is full, and the writer must then hold the word and keep `wr_valid` high. The receive side applies no back-pressure: each received byte is shown with a one-cycle `rx_valid` pulse. The configuration inputs should only change while chip select is high.

Top module: `spi_burst_master`

## Requirements
- R1: A word is accepted on a clock edge where both `wr_valid` and `wr_ready` are high. The queue holds 2 words. `fifo_full` is high and `wr_ready` is low while 2 words are queued. `fifo_empty` is high when no words are queued.
- R2: Each half period of `sclk` lasts `cfg_div`+1 clock cycles, so a value of 0 gives half the system clock rate. While no frame is shifting, `sclk` sits at the `cfg_cpol` level.
- R3: Every frame shifts 8 bits, most significant bit first, with exactly 8 `sclk` pulses (16 transitions).
  - With `cfg_cpha`=0, a bit is on `mosi` before the leading edge, the slave samples it on the leading edge, and the next bit is launched on the trailing edge.
  - With `cfg_cpha`=1, a bit is launched on the leading edge and sampled on the trailing edge.
  - The leading edge is the transition away from the `cfg_cpol` level.
- R4: `miso` is sampled on the same edge that the slave uses to sample `mosi`, and the bits fill `rx_data` most significant bit first. `rx_valid` is high for exactly one cycle after each frame, together with that frame's byte.
- R5: Once the queue is non-empty, `cs_n` goes low on the next clock edge, and the first frame starts after `cfg_setup` bit times.
- R6: When the queue still holds a word at the end of a frame, the next frame follows with `cs_n` kept low. `cs_n` only rises when the queue was empty as the final frame or hold ended.
- R7: When `cfg_gap` is greater than 0, that many bit times separate consecutive frames of a burst, with `sclk` at its idle level.
- R8: After the last frame, `cs_n` stays low for `cfg_hold` extra bit times.
  - Over a whole burst of K frames, `cs_n` is low for (`cfg_div`+1)·(2·setup + 16·K + 2·gap·(K−1) + 2·hold) cycles.
- R9: A word written during the hold completes the whole hold. Its frame then starts at once, with no setup delay and with `cs_n` still low. This adds 16 + 2·hold half periods to the chip-select window.
- R10: After reset, `cs_n` is 1, `sclk` is 0 (with `cfg_cpol`=0), `fifo_empty` is 1, `wr_ready` is 1, and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Half-period divider; half period = cfg_div+1 cycles |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_setup | input | 4 | Bit times between chip-select fall and first frame |
| cfg_hold | input | 4 | Extra bit times chip select stays low after last frame |
| cfg_gap | input | 4 | Idle bit times between frames of a burst |
| wr_valid | input | 1 | Write port: word offered |
| wr_ready | output | 1 | Write port: queue can take a word |
| wr_data | input | 8 | Word to transmit |
| fifo_full | output | 1 | Queue holds 2 words |
| fifo_empty | output | 1 | Queue holds no word |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new byte |
| rx_data | output | 8 | Last received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The main function is exercised with a table of bursts. The table covers all four polarity/phase pairs, divider values 0 to 2, and bursts of 1 to 3 frames, with setup, spacing and hold set to zero or non-zero. A behavioural slave in the bench captures `mosi` and drives `miso`. Its captured bytes show whether the launch edge is correct, and the count of sclk transitions per burst shows whether any stray pulse appears in a gap or hold. The chip-select window measured in cycles separates divider, setup, spacing and hold errors from one another. Directed tests cover the following:
- the reset state;
- back-pressure from a full queue with a slow clock;
- a word written in the middle of a hold, whose frame must wait for the whole hold.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_XFER,
    SQ_GAP,
    SQ_HOLD
  } sq_state_e;
endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == FULLC);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= '0;
      else if (do_push && wp == AW'(g))  mem[g] <= push_data;
    end
  end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_frm_pkg::*;
#(
  parameter int W  = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_hold,
  input  logic [TW-1:0] cfg_gap,
  input  logic          q_empty,
  input  logic [W-1:0]  q_head,
  input  logic          miso,
  output logic          pop,
  output logic          run,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic          rx_valid,
  output logic [W-1:0]  rx_data
);
  localparam int HW = $clog2(2 * W);
  localparam logic [HW-1:0] LASTH = HW'(2 * W - 1);

  sq_state_e     st;
  logic [HW-1:0] h;
  logic [TW:0]   wc;
  logic [TW-1:0] wait_n;
  logic [TW:0]   wlast;
  logic          wdone, fend;
  logic [W-1:0]  tx_sh, rx_sh;

  always_comb begin
    case (st)
      SQ_SETUP: wait_n = cfg_setup;
      SQ_GAP:   wait_n = cfg_gap;
      default:  wait_n = cfg_hold;
    endcase
  end

  assign wlast = {wait_n, 1'b0} - {{TW{1'b0}}, 1'b1};
  assign wdone = (wc == wlast);
  assign fend  = (st == SQ_XFER) && tick && (h == LASTH);

  assign pop = ((st == SQ_IDLE) && !q_empty) ||
               (fend && !q_empty) ||
               ((st == SQ_HOLD) && tick && wdone && !q_empty);

  assign run  = (st != SQ_IDLE);
  assign cs_n = (st == SQ_IDLE);
  assign sclk = (st == SQ_XFER) ? (cfg_cpol ^ h[0] ^ cfg_cpha) : cfg_cpol;
  assign mosi = (st == SQ_IDLE) ? 1'b0 : tx_sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      h        <= '0;
      wc       <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        SQ_IDLE: if (!q_empty) begin
          tx_sh <= q_head;
          h     <= '0;
          wc    <= '0;
          st    <= (cfg_setup != '0) ? SQ_SETUP : SQ_XFER;
        end
        SQ_SETUP, SQ_GAP: if (tick) begin
          if (wdone) begin
            st <= SQ_XFER;
            wc <= '0;
          end else begin
            wc <= wc + 1'b1;
          end
        end
        SQ_XFER: if (tick) begin
          if (!h[0]) rx_sh <= {rx_sh[W-2:0], miso};
          else       tx_sh <= {tx_sh[W-2:0], 1'b0};
          if (h == LASTH) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_sh;
            h        <= '0;
            wc       <= '0;
            if (!q_empty) begin
              tx_sh <= q_head;
              st    <= (cfg_gap != '0) ? SQ_GAP : SQ_XFER;
            end else begin
              st <= (cfg_hold != '0) ? SQ_HOLD : SQ_IDLE;
            end
          end else begin
            h <= h + 1'b1;
          end
        end
        SQ_HOLD: if (tick) begin
          if (wdone) begin
            wc <= '0;
            if (!q_empty) begin
              tx_sh <= q_head;
              h     <= '0;
              st    <= SQ_XFER;
            end else begin
              st <= SQ_IDLE;
            end
          end else begin
            wc <= wc + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int DIV_W      = 8,
  parameter int TIME_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [TIME_W-1:0] cfg_setup,
  input  logic [TIME_W-1:0] cfg_hold,
  input  logic [TIME_W-1:0] cfg_gap,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic              pop, run, tick;
  logic [DATA_W-1:0] head;

  assign wr_ready = !fifo_full;

  spi_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_valid),
    .push_data (wr_data),
    .pop       (pop),
    .head      (head),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  spi_half_tick #(.DW(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .div   (cfg_div),
    .tick  (tick)
  );

  spi_frame_seq #(.W(DATA_W), .TW(TIME_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .cfg_setup (cfg_setup),
    .cfg_hold  (cfg_hold),
    .cfg_gap   (cfg_gap),
    .q_empty   (fifo_empty),
    .q_head    (head),
    .miso      (miso),
    .pop       (pop),
    .run       (run),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
  );
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic fifo_full,
  input logic fifo_empty,
  input logic rx_valid,
  input logic sclk,
  input logic cs_n
);
  assert_full_not_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  assert_sclk_idle_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cfg_cpol));

  assert_rx_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_cs_release_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(fifo_empty));

  assert_no_edge_while_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(cfg_cpol)) |-> $stable(sclk));
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (.*);

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_div = '0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [3:0] cfg_setup = '0, cfg_hold = '0, cfg_gap = '0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, fifo_full, fifo_empty, rx_valid, sclk, mosi, miso, cs_n;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_gap(cfg_gap), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  typedef struct packed {
    logic [7:0] div;
    logic       cpol;
    logic       cpha;
    logic [3:0] setup;
    logic [3:0] hold;
    logic [3:0] gap;
    logic [1:0] k;
    logic [7:0] d0, d1, d2;
    logic [7:0] s0, s1, s2;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 2'd1, 8'hA5, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00},
    '{8'd0, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0, 2'd2, 8'h81, 8'h7E, 8'h00, 8'hC3, 8'h18, 8'h00},
    '{8'd1, 1'b1, 1'b0, 4'd1, 4'd2, 4'd0, 2'd2, 8'hF0, 8'h0F, 8'h00, 8'h55, 8'hAA, 8'h00},
    '{8'd2, 1'b1, 1'b1, 4'd0, 4'd1, 4'd2, 2'd3, 8'h12, 8'h34, 8'h56, 8'h9A, 8'hBC, 8'hDE},
    '{8'd0, 1'b0, 1'b1, 4'd2, 4'd0, 4'd1, 2'd3, 8'hFF, 8'h00, 8'h80, 8'h01, 8'hFE, 8'h7F},
    '{8'd0, 1'b0, 1'b0, 4'd0, 4'd1, 4'd3, 2'd2, 8'h6D, 8'hB2, 8'h00, 8'h44, 8'h22, 8'h00}
  };

  int n_chk = 0, n_fail = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model and monitors
  logic [7:0] sl_tx [3];
  logic [7:0] sl_got [4];
  logic [7:0] m_got [4];
  logic [7:0] sl_rx, miso_sh;
  int sl_bits, sl_idx, m_idx, cs_cnt, edges;
  logic sclk_prev = 1'b0, cs_prev = 1'b1;

  assign miso = miso_sh[7];

  always @(negedge clk) begin
    if (!cs_n) cs_cnt++;
    if (rst_n && sclk != sclk_prev && (!cs_n || !cs_prev)) begin
      edges++;
      if ((cfg_cpha ? (sclk == cfg_cpol) : (sclk != cfg_cpol))) begin
        sl_rx = {sl_rx[6:0], mosi};
        sl_bits++;
        if (sl_bits == 8) begin
          if (sl_idx < 4) sl_got[sl_idx] = sl_rx;
          sl_idx++;
          sl_bits = 0;
          miso_sh = (sl_idx < 3) ? sl_tx[sl_idx] : 8'h00;
        end else begin
          miso_sh = {miso_sh[6:0], 1'b0};
        end
      end
    end
    if (rx_valid) begin
      if (m_idx < 4) m_got[m_idx] = rx_data;
      m_idx++;
    end
    sclk_prev = sclk;
    cs_prev = cs_n;
  end

  task automatic clear_mon(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    sl_tx[0] = a; sl_tx[1] = b; sl_tx[2] = c;
    miso_sh = a;
    sl_bits = 0; sl_idx = 0; m_idx = 0; cs_cnt = 0; edges = 0; sl_rx = '0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(cs_n && fifo_empty)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int watchdog = 0;
  always @(posedge clk) begin
    watchdog++;
    if (watchdog > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", watchdog, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [3];
    logic [7:0] s [3];
    int k, expw;
    clear_mon(8'h00, 8'h00, 8'h00);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(cs_n == 1'b1, "R10 cs_n", cs_n, 1);
    check(sclk == 1'b0, "R10 sclk", sclk, 0);
    check(fifo_empty == 1'b1, "R10 fifo_empty", fifo_empty, 1);
    check(wr_ready == 1'b1, "R10 wr_ready", wr_ready, 1);
    check(rx_valid == 1'b0, "R10 rx_valid", rx_valid, 0);

    // table of bursts: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_div = VEC[i].div; cfg_cpol = VEC[i].cpol; cfg_cpha = VEC[i].cpha;
      cfg_setup = VEC[i].setup; cfg_hold = VEC[i].hold; cfg_gap = VEC[i].gap;
      k = int'(VEC[i].k);
      d[0] = VEC[i].d0; d[1] = VEC[i].d1; d[2] = VEC[i].d2;
      s[0] = VEC[i].s0; s[1] = VEC[i].s1; s[2] = VEC[i].s2;
      repeat (2) @(negedge clk);
      clear_mon(s[0], s[1], s[2]);
      for (int j = 0; j < k; j++) push(d[j]);
      wait_idle();
      expw = (int'(VEC[i].div) + 1) * (2 * int'(VEC[i].setup) + 16 * k
             + 2 * int'(VEC[i].gap) * (k - 1) + 2 * int'(VEC[i].hold));
      for (int j = 0; j < k; j++) begin
        check(sl_got[j] == d[j], $sformatf("R3 vec%0d mosi byte%0d", i, j), sl_got[j], d[j]);
        check(m_got[j] == s[j], $sformatf("R4 vec%0d rx byte%0d", i, j), m_got[j], s[j]);
      end
      check(m_idx == k, $sformatf("R4 vec%0d rx_valid pulses", i), m_idx, k);
      check(edges == 16 * k, $sformatf("R3/R7 vec%0d sclk transitions", i), edges, 16 * k);
      check(cs_cnt == expw, $sformatf("R2/R5/R6/R8 vec%0d cs window", i), cs_cnt, expw);
      check(sclk == VEC[i].cpol, $sformatf("R2 vec%0d idle level", i), sclk, VEC[i].cpol);
    end

    // R1 back-pressure with a slow clock
    @(negedge clk);
    cfg_div = 8'd20; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_setup = '0; cfg_hold = '0; cfg_gap = '0;
    repeat (2) @(negedge clk);
    clear_mon(8'h11, 8'h22, 8'h33);
    push(8'hC1);
    push(8'hC2);
    push(8'hC3);
    check(fifo_full == 1'b1, "R1 fifo_full with 2 queued", fifo_full, 1);
    check(wr_ready == 1'b0, "R1 wr_ready low when full", wr_ready, 0);
    check(fifo_empty == 1'b0, "R1 fifo_empty low when full", fifo_empty, 0);
    wait_idle();
    check(sl_got[0] == 8'hC1 && sl_got[1] == 8'hC2 && sl_got[2] == 8'hC3,
          "R1 order after back-pressure", sl_got[2], 8'hC3);
    check(cs_cnt == 21 * 48, "R6 three-frame window", cs_cnt, 21 * 48);

    // R9 word written during hold
    @(negedge clk);
    cfg_div = 8'd1; cfg_hold = 4'd3;
    repeat (2) @(negedge clk);
    clear_mon(8'h5A, 8'hE7, 8'h00);
    push(8'h3B);
    while (!rx_valid) @(negedge clk);
    check(cs_n == 1'b0, "R8 cs held after last frame", cs_n, 0);
    push(8'hD4);
    wait_idle();
    check(cs_cnt == 2 * (32 + 6 + 6), "R9 hold completes before new frame", cs_cnt, 88);
    check(sl_got[1] == 8'hD4, "R9 frame after hold", sl_got[1], 8'hD4);
    check(m_got[1] == 8'hE7, "R9 rx after hold", m_got[1], 8'hE7);
    check(edges == 32, "R9 no stray pulse in hold", edges, 32);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule